// File: doc/BRIEF.md
# Transparent Address Window Matcher

This block decides, for one class of memory access (data or instruction), whether a logical address lies inside one of two programmable windows that bypass translation. Inside such a window the physical address is the logical address. Each window is described by one 32-bit control word. The control word holds:

- an 8-bit base and an 8-bit don't-care mask that are compared against the top address byte;
- an enable bit;
- a privilege selector;
- a 2-bit cache-mode field;
- a write-protect bit;
- two free attribute bits that are passed out to the external bus on a hit.

Software loads the control words through a simple port that moves whole 32-bit words only. The access side has no clock on its path. Each cycle the surrounding memory unit presents an address, a supervisor flag and a write flag. In the same cycle it gets back a hit flag, the cache mode, the attribute bits and a write-protect fault flag.

The hit decision ignores any global translation enable and any external translation-disable input. None of those signals enter this block. When both windows claim the same access, window 0 wins.

Top module: `ttm_top`

## Requirements
- R1: After reset both control words read as 0x00000000, and no access produces a hit, a fault, or a nonzero attribute output.
- R2: A write with `cfg_wr` high is stored at the next rising clock edge into the word chosen by `cfg_sel`. `cfg_rdata` always shows the word chosen by `cfg_sel`. Bits 12..10, 7, 4, 3, 1 and 0 read as zero whatever was written, so the read-back value is the written value AND 0xFFFFE364.
- R3: A window matches only when addr[31:24] equals base bits [31:24] in every bit position where mask bits [23:16] hold 0. A mask bit of 1 makes that address bit a don't-care.
- R4: Bit 15 of a word is the enable. A word with bit 15 clear never matches, whatever its other fields hold.
- R5: Bits [14:13] select privilege: 00 matches only when `acc_super` is 0, 01 matches only when `acc_super` is 1, and 1x matches either.
- R6: When both windows match, the cache mode, attribute bits and write-protect bit are taken from word 0.
- R7: On a hit, `cache_mode` carries bits [6:5] of the winning word, and `upa[1]` and `upa[0]` carry its bits 9 and 8. Whenever `hit` is 0, `cache_mode` and `upa` are 0.
- R8: If a write access (`acc_write` = 1) matches and the winning word has bit 2 set, then `wp_fault` is 1 and `hit` is 0 in that cycle. Read accesses to a protected window hit normally and raise no fault.
- R9: The access outputs respond in the same cycle to `acc_addr`, `acc_super` and `acc_write`, with no register in between.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write strobe for the control word selected |
| cfg_sel | input | 1 | Control word select (0 or 1) |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read-back of selected control word |
| acc_addr | input | 32 | Logical address of the access |
| acc_super | input | 1 | 1 = supervisor access, 0 = user access |
| acc_write | input | 1 | 1 = write access |
| hit | output | 1 | Access lies in an untranslated window |
| cache_mode | output | 2 | Cache mode of the winning window |
| wp_fault | output | 1 | Write to a write-protected window |
| upa | output | 2 | User attribute bits for the external transfer |

## Verification
A control-word write is due on `cfg_rdata` and on the access outputs one clock edge after the strobe. The bench therefore lowers the strobe at the next falling edge and only then reads back or probes. The access results have no register in their path, so they are due in the same cycle. The bench drives each access at a falling edge and samples one nanosecond later, well before the next rising edge, and compares the result against a model built from the words it has written.

// File: rtl/ttm_pkg.sv
package ttm_pkg;

    localparam int WORD_W   = 32;
    localparam int BYTE_W   = 8;

    // field positions inside a control word
    localparam int BASE_LSB = 24;
    localparam int MASK_LSB = 16;
    localparam int EN_BIT   = 15;
    localparam int PRIV_LSB = 13;
    localparam int UPA_LSB  = 8;
    localparam int CM_LSB   = 5;
    localparam int WP_BIT   = 2;

    // bits that survive a write; the rest read as zero
    localparam logic [WORD_W-1:0] KEEP_MASK = 32'hFFFF_E364;

    typedef struct packed {
        logic [BYTE_W-1:0] base;
        logic [BYTE_W-1:0] dcare;
        logic              en;
        logic [1:0]        priv;
        logic [1:0]        upa;
        logic [1:0]        cmode;
        logic              wp;
    } ttm_entry_t;

    function automatic ttm_entry_t ttm_decode(input logic [WORD_W-1:0] w);
        ttm_entry_t e;
        e.base  = w[BASE_LSB +: BYTE_W];
        e.dcare = w[MASK_LSB +: BYTE_W];
        e.en    = w[EN_BIT];
        e.priv  = w[PRIV_LSB +: 2];
        e.upa   = w[UPA_LSB +: 2];
        e.cmode = w[CM_LSB +: 2];
        e.wp    = w[WP_BIT];
        return e;
    endfunction

endpackage

// File: rtl/ttm_regfile.sv
module ttm_regfile
    import ttm_pkg::*;
#(
    parameter int N_WIN = 2,
    localparam int SEL_W = (N_WIN > 1) ? $clog2(N_WIN) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [SEL_W-1:0]            sel,
    input  logic [WORD_W-1:0]           wdata,
    output logic [WORD_W-1:0]           rdata,
    output logic [N_WIN-1:0][WORD_W-1:0] words
);

    logic [N_WIN-1:0][WORD_W-1:0] word_q;

    for (genvar i = 0; i < N_WIN; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q[i] <= '0;
            end else if (wr_en && (sel == SEL_W'(i))) begin
                word_q[i] <= wdata & KEEP_MASK;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < N_WIN; i++) begin
            if (sel == SEL_W'(i)) rdata = word_q[i];
        end
    end

    assign words = word_q;

endmodule

// File: rtl/ttm_match.sv
module ttm_match
    import ttm_pkg::*;
(
    input  ttm_entry_t        ent,
    input  logic [BYTE_W-1:0] addr_hi,
    input  logic              super_i,
    output logic              match
);

    logic addr_ok;
    logic priv_ok;

    always_comb begin
        addr_ok = (((addr_hi ^ ent.base) & ~ent.dcare) == '0);
        priv_ok = ent.priv[1] | (ent.priv[0] == super_i);
        match   = ent.en & addr_ok & priv_ok;
    end

endmodule

// File: rtl/ttm_resolve.sv
module ttm_resolve
    import ttm_pkg::*;
#(
    parameter int N_WIN = 2
) (
    input  logic [N_WIN-1:0]       match,
    input  ttm_entry_t [N_WIN-1:0] ents,
    input  logic                   is_write,
    output logic                   hit,
    output logic [1:0]             cache_mode,
    output logic                   wp_fault,
    output logic [1:0]             upa
);

    ttm_entry_t win;
    logic       any;
    logic       blocked;

    // lowest index wins: scan downwards so index 0 is applied last
    always_comb begin
        win = '0;
        any = 1'b0;
        for (int i = N_WIN - 1; i >= 0; i--) begin
            if (match[i]) begin
                win = ents[i];
                any = 1'b1;
            end
        end
        blocked    = any & is_write & win.wp;
        wp_fault   = blocked;
        hit        = any & ~blocked;
        cache_mode = hit ? win.cmode : 2'b00;
        upa        = hit ? win.upa   : 2'b00;
    end

endmodule

// File: rtl/ttm_top.sv
module ttm_top
    import ttm_pkg::*;
#(
    parameter int N_WIN = 2,
    localparam int SEL_W = (N_WIN > 1) ? $clog2(N_WIN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic [31:0]       acc_addr,
    input  logic              acc_super,
    input  logic              acc_write,
    output logic              hit,
    output logic [1:0]        cache_mode,
    output logic              wp_fault,
    output logic [1:0]        upa
);

    logic [N_WIN-1:0][WORD_W-1:0] words;
    ttm_entry_t [N_WIN-1:0]       ents;
    logic [N_WIN-1:0]             match;

    ttm_regfile #(.N_WIN(N_WIN)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_wr),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .words (words)
    );

    for (genvar i = 0; i < N_WIN; i++) begin : g_win
        assign ents[i] = ttm_decode(words[i]);
        ttm_match u_match (
            .ent     (ents[i]),
            .addr_hi (acc_addr[31 -: BYTE_W]),
            .super_i (acc_super),
            .match   (match[i])
        );
    end

    ttm_resolve #(.N_WIN(N_WIN)) u_res (
        .match      (match),
        .ents       (ents),
        .is_write   (acc_write),
        .hit        (hit),
        .cache_mode (cache_mode),
        .wp_fault   (wp_fault),
        .upa        (upa)
    );

endmodule

// File: rtl/ttm_checker.sv
module ttm_checker
    import ttm_pkg::*;
#(
    parameter int SEL_W = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr,
    input logic [SEL_W-1:0] cfg_sel,
    input logic [31:0]      cfg_wdata,
    input logic [31:0]      cfg_rdata,
    input logic             acc_write,
    input logic             hit,
    input logic [1:0]       cache_mode,
    input logic             wp_fault,
    input logic [1:0]       upa
);

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata & ~KEEP_MASK) == '0);                                  // R2

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (cfg_sel != $past(cfg_sel)) ||
                   (cfg_rdata == ($past(cfg_wdata) & KEEP_MASK)));        // R2

    AST_ATTR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (cache_mode == 2'b00 && upa == 2'b00));                  // R7

    AST_FAULT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        wp_fault |-> !hit);                                               // R8

    AST_FAULT_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wp_fault |-> acc_write);                                          // R8

endmodule

bind ttm_top ttm_checker #(.SEL_W(SEL_W)) u_chk (.*);

// File: tb/sim_ttm_top.sv
`timescale 1ns/1ps
module sim_ttm_top;

    localparam logic [31:0] KEEP = 32'hFFFF_E364;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [0:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [31:0] acc_addr = '0;
    logic        acc_super = 1'b0;
    logic        acc_write = 1'b0;
    logic        hit;
    logic [1:0]  cache_mode;
    logic        wp_fault;
    logic [1:0]  upa;

    int n_cmp = 0;
    int n_bad = 0;
    logic done = 1'b0;
    logic [31:0] mdl [2];

    always #2 clk = ~clk;

    ttm_top u0 (.*);

    function automatic logic win_hit(input logic [31:0] w, input logic [31:0] a, input logic s);
        logic ok_a, ok_p;
        ok_a = (((a[31:24] ^ w[31:24]) & ~w[23:16]) == 8'h00);   // R3
        ok_p = w[14] ? 1'b1 : (w[13] == s);                       // R5
        return w[15] & ok_a & ok_p;                               // R4
    endfunction

    // expected {hit, cache_mode, wp_fault, upa}
    function automatic logic [5:0] expect_out(input logic [31:0] a, input logic s, input logic wr);
        logic h0, h1, any, flt, h;
        logic [31:0] w;
        h0 = win_hit(mdl[0], a, s);
        h1 = win_hit(mdl[1], a, s);
        any = h0 | h1;
        w = h0 ? mdl[0] : mdl[1];                                 // R6
        flt = any & wr & w[2];                                    // R8
        h = any & ~flt;
        return {h, h ? w[6:5] : 2'b00, flt, h ? w[9:8] : 2'b00};  // R7
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_word(input logic sel, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        mdl[sel] = d & KEEP;
    endtask

    task automatic rd_check(input string tag, input logic sel);
        @(negedge clk);
        cfg_sel = sel;
        #1;
        check(tag, cfg_rdata, mdl[sel]);
    endtask

    task automatic acc_check(input string tag, input logic [31:0] a, input logic s, input logic wr);
        @(negedge clk);
        acc_addr = a; acc_super = s; acc_write = wr;
        #1;
        check(tag, {26'd0, hit, cache_mode, wp_fault, upa}, {26'd0, expect_out(a, s, wr)});
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        mdl[0] = '0; mdl[1] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        rd_check("R1 word0 after reset", 1'b0);
        rd_check("R1 word1 after reset", 1'b1);
        acc_check("R1 no hit after reset", 32'h0000_0000, 1'b1, 1'b0);

        // R2 reserved bits read as zero
        wr_word(1'b0, 32'hFFFF_FFFF);
        rd_check("R2 readback all ones", 1'b0);
        check("R2 literal keep", cfg_rdata, 32'hFFFF_E364);
        wr_word(1'b0, 32'h0000_0000);

        // R3 exact and masked compare
        wr_word(1'b0, 32'h4000_C020);           // base 40, mask 00, en, any priv, cm 01
        acc_check("R3 exact match", 32'h40AB_CDEF, 1'b0, 1'b0);
        acc_check("R3 off by one byte", 32'h41AB_CDEF, 1'b0, 1'b0);
        wr_word(1'b0, 32'h4003_C040);           // mask low two bits
        acc_check("R3 masked 43", 32'h4300_0000, 1'b1, 1'b0);
        acc_check("R3 masked outside 44", 32'h4400_0000, 1'b1, 1'b0);
        wr_word(1'b0, 32'h0081_C000);           // non-contiguous mask
        acc_check("R3 noncontig 81", 32'h8100_0000, 1'b0, 1'b0);
        acc_check("R3 noncontig 02", 32'h0200_0000, 1'b0, 1'b0);

        // R4 disabled word
        wr_word(1'b0, 32'h40FF_4360);           // bit15 clear
        acc_check("R4 disabled never hits", 32'h4000_0000, 1'b1, 1'b0);

        // R5 privilege field
        wr_word(1'b0, 32'h2000_8000);           // 00 user only
        acc_check("R5 user-only user", 32'h2000_0000, 1'b0, 1'b0);
        acc_check("R5 user-only super", 32'h2000_0000, 1'b1, 1'b0);
        wr_word(1'b0, 32'h2000_A000);           // 01 super only
        acc_check("R5 super-only super", 32'h2000_0000, 1'b1, 1'b0);
        acc_check("R5 super-only user", 32'h2000_0000, 1'b0, 1'b0);

        // R6 priority and R7 attributes
        wr_word(1'b0, 32'h50FF_C120);           // all addresses, upa 01, cm 01
        wr_word(1'b1, 32'h5000_C264);           // upa 10, cm 11, wp
        acc_check("R6 word0 wins", 32'h5000_0000, 1'b0, 1'b1);
        acc_check("R7 attr from word0", 32'h6000_0000, 1'b1, 1'b0);
        wr_word(1'b0, 32'h0000_0000);
        acc_check("R7 attr from word1", 32'h5000_0000, 1'b0, 1'b0);

        // R8 write protect
        acc_check("R8 write fault", 32'h5000_0000, 1'b0, 1'b1);
        acc_check("R8 read no fault", 32'h5000_0000, 1'b1, 1'b0);
        acc_check("R8 write miss no fault", 32'h5100_0000, 1'b0, 1'b1);

        // R9 same-cycle response: change address without any clock of writes
        @(negedge clk);
        acc_addr = 32'h5000_0000; acc_super = 1'b0; acc_write = 1'b0;
        #0.5;
        check("R9 same cycle hit", {31'd0, hit}, 32'd1);
        acc_addr = 32'h5100_0000;
        #0.5;
        check("R9 same cycle miss", {31'd0, hit}, 32'd0);

        // random phase
        for (int it = 0; it < 600; it++) begin
            if ($urandom_range(3) == 0) begin
                wr_word(1'($urandom_range(1)), $urandom() | 32'h0000_8000 * $urandom_range(1));
                rd_check("R2 random readback", 1'($urandom_range(1)));
            end else begin
                logic [31:0] a;
                a = $urandom();
                if ($urandom_range(1) == 1)
                    a[31:24] = mdl[$urandom_range(1)][31:24] ^ (8'h01 << $urandom_range(7)) * $urandom_range(1);
                acc_check("R3 R5 R6 R7 R8 random access", a, 1'($urandom_range(1)), 1'($urandom_range(1)));
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule